// File: doc/BRIEF.md
# PHY Link Bring-Up Sequencer

This block drives the start-of-day configuration of an Ethernet PHY through a register-level management master. One pulse on `start` runs a fixed sequence. It soft-resets the PHY and waits for that reset to finish, then silences every PHY interrupt source. Next it reads the PHY's ability bits and turns them into an advertisement word, writes that word, and kicks off autonegotiation. Finally it waits for negotiation to finish, and if the link partner signals a remote fault it asks for negotiation again.

Each register access is one request on a simple valid/done port: the block holds the request until the management master answers with a one-cycle done pulse, and read data arrives alongside that pulse. Polls are spaced by an external `tick` strobe, so the same logic serves a real 500 ms interval on silicon and a few cycles in simulation. When the sequence ends, the block raises `done` and keeps it high. It also reports `failed`, and `rst_timeout` when the PHY never came out of reset. These flags stay valid until the next `start`.

Top module: `phy_bringup_seq`

## Requirements
- R1: The first request after an accepted `start` is a write of 0x8000 (only bit 15, the reset bit, set) to register 0.
- R2: Register 0 is then read; a read with bit 15 clear moves on, otherwise a further read follows only after a `tick` has been seen, for at most RST_POLLS reads in total (a clear bit on the last allowed read still counts as success).
- R3: If all RST_POLLS reads show bit 15 set, the sequence ends with `done`, `failed` and `rst_timeout` all high and issues no further request.
- R4: After reset completes, 0xFFFF is written to register 18 (the interrupt mask).
- R5: Register 1 is read once and the advertisement word is built from it: bits 4:0 = 00001 always; bit 5 = status bit 11 (10 half), bit 6 = status bit 12 (10 full), bit 7 = status bit 13 (100 half), bit 8 = status bit 14 (100 full), bit 9 = status bit 15 (T4); all other bits zero.
- R6: The advertisement word is written to register 4, followed by a write of 0x1200 (enable bit 12, restart bit 9) to register 0.
- R7: Register 1 is then polled for bit 5 (negotiation complete), each further poll only after a `tick`, for at most ANEG_POLLS reads.
- R8: A poll that shows bit 5 clear and bit 4 (remote fault) set causes, after the next `tick`, a write of 0x3300 (bits 13, 12, 9, 8) to register 0 before the next poll.
- R9: A poll with bit 5 set ends the sequence with `done` high and `failed` equal to that read's bit 4; exhausting ANEG_POLLS polls ends it with `done` and `failed` high and `rst_timeout` low.
- R10: A request holds `req_valid` and its fields steady until `mgmt_done`, and requests appear only while `busy`.
- R11: `start` is ignored while `busy`; an accepted `start` clears `done`, `failed` and `rst_timeout`, which otherwise hold their value after the sequence ends.
- R12: Every request carries the PHY address given by the PHY_ADDR parameter on `req_phy`.
- R13: After reset, `busy`, `done`, `failed`, `rst_timeout` and `req_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up sequence (ignored while busy) |
| tick | input | 1 | One-cycle strobe marking each poll interval |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | The last sequence has ended |
| failed | output | 1 | The last sequence ended in failure |
| rst_timeout | output | 1 | The last sequence gave up waiting for PHY reset |
| req_valid | output | 1 | Management request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | PHY_AW | PHY address of the request |
| req_reg | output | REG_AW | Register number of the request |
| req_wdata | output | DATA_W | Write data |
| mgmt_done | input | 1 | One-cycle completion pulse from the management master |
| mgmt_rdata | input | DATA_W | Read data, valid with `mgmt_done` |

## Verification
The hardest situation to reach is a remote fault during negotiation, because it only matters in combination with the poll index. A fault seen on an incomplete poll must trigger the restart write. A fault on the very poll that reports completion must instead produce a failure with no restart. The bench's PHY model returns scripted status words per poll number, with a per-poll fault mask and a completion index, so each of these orderings is reached on purpose. The same script places the reset bit clearing exactly on the last permitted poll, and never clearing at all, to pin down both edges of the reset retry bound.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_WR_RST,
      S_RD_RST,
      S_WT_RST,
      S_WR_MASK,
      S_RD_CAP,
      S_WR_ADV,
      S_WR_ANEG,
      S_RD_ANEG,
      S_WT_ANEG,
      S_WR_RETRY
   } seq_state_e;

   // control register bit positions
   localparam int CTL_RESET   = 15;
   localparam int CTL_SPEED   = 13;
   localparam int CTL_AN_EN   = 12;
   localparam int CTL_AN_RST  = 9;
   localparam int CTL_DUPLEX  = 8;

   // status register bit positions
   localparam int STS_AN_DONE = 5;
   localparam int STS_RFAULT  = 4;
   localparam int STS_CAP_LSB = 11;   // 10H,10F,100H,100F,T4 upward

   // advertisement register layout
   localparam int ADV_CAP_LSB = 5;    // same order as the status abilities
   localparam int NUM_CAPS    = 5;
   localparam logic [4:0] ADV_SELECTOR = 5'b00001;

   localparam int MGMT_DW = 16;

   function automatic logic [MGMT_DW-1:0] bitword(input int a, input int b,
                                                  input int c, input int d);
      logic [MGMT_DW-1:0] w;
      w = '0;
      if (a >= 0) w[a] = 1'b1;
      if (b >= 0) w[b] = 1'b1;
      if (c >= 0) w[c] = 1'b1;
      if (d >= 0) w[d] = 1'b1;
      return w;
   endfunction

endpackage

// File: rtl/pbs_cap_map.sv
module pbs_cap_map
   import pbs_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] status_word,
   output logic [DATA_W-1:0] adv_word
);

   localparam int TOP_FREE = ADV_CAP_LSB + NUM_CAPS;

   assign adv_word[4:0] = ADV_SELECTOR;

   for (genvar g = 0; g < NUM_CAPS; g++) begin : g_cap
      assign adv_word[ADV_CAP_LSB + g] = status_word[STS_CAP_LSB + g];
   end

   if (TOP_FREE < DATA_W) begin : g_zero_top
      assign adv_word[DATA_W-1:TOP_FREE] = '0;
   end

endmodule

// File: rtl/pbs_retry_cnt.sv
module pbs_retry_cnt #(
   parameter int LIMIT = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bump,
   output logic last
);

   if (LIMIT <= 1) begin : g_single
      // one attempt only: every poll is the last
      assign last = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(LIMIT + 1);
      localparam logic [CW-1:0] LAST_IDX = CW'(LIMIT - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (clr) begin
            cnt_q <= '0;
         end else if (bump && cnt_q != LAST_IDX) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign last = (cnt_q == LAST_IDX);
   end

endmodule

// File: rtl/pbs_req_encode.sv
module pbs_req_encode
   import pbs_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int REG_AW     = 5,
   parameter int CTRL_ADDR  = 0,
   parameter int STAT_ADDR  = 1,
   parameter int ADV_ADDR   = 4,
   parameter int IMASK_ADDR = 18
) (
   input  seq_state_e        state,
   input  logic [DATA_W-1:0] adv_word,
   output logic              valid,
   output logic              write,
   output logic [REG_AW-1:0] regnum,
   output logic [DATA_W-1:0] wdata
);

   localparam logic [DATA_W-1:0] W_RESET = DATA_W'(bitword(CTL_RESET, -1, -1, -1));
   localparam logic [DATA_W-1:0] W_ANEG  = DATA_W'(bitword(CTL_AN_EN, CTL_AN_RST, -1, -1));
   localparam logic [DATA_W-1:0] W_RETRY = DATA_W'(bitword(CTL_AN_EN, CTL_AN_RST,
                                                           CTL_SPEED, CTL_DUPLEX));
   localparam logic [DATA_W-1:0] W_MASK  = '1;

   localparam logic [REG_AW-1:0] A_CTRL  = REG_AW'(CTRL_ADDR);
   localparam logic [REG_AW-1:0] A_STAT  = REG_AW'(STAT_ADDR);
   localparam logic [REG_AW-1:0] A_ADV   = REG_AW'(ADV_ADDR);
   localparam logic [REG_AW-1:0] A_IMASK = REG_AW'(IMASK_ADDR);

   always_comb begin
      valid  = 1'b1;
      write  = 1'b0;
      regnum = A_CTRL;
      wdata  = '0;
      unique case (state)
         S_WR_RST: begin
            write = 1'b1;
            wdata = W_RESET;
         end
         S_RD_RST: begin
            regnum = A_CTRL;
         end
         S_WR_MASK: begin
            write  = 1'b1;
            regnum = A_IMASK;
            wdata  = W_MASK;
         end
         S_RD_CAP, S_RD_ANEG: begin
            regnum = A_STAT;
         end
         S_WR_ADV: begin
            write  = 1'b1;
            regnum = A_ADV;
            wdata  = adv_word;
         end
         S_WR_ANEG: begin
            write = 1'b1;
            wdata = W_ANEG;
         end
         S_WR_RETRY: begin
            write = 1'b1;
            wdata = W_RETRY;
         end
         default: begin
            valid = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
   import pbs_pkg::*;
#(
   parameter int             DATA_W     = 16,
   parameter int             REG_AW     = 5,
   parameter int             PHY_AW     = 5,
   parameter logic [4:0]     PHY_ADDR   = 5'd0,
   parameter int             RST_POLLS  = 6,
   parameter int             ANEG_POLLS = 20,
   parameter int             CTRL_ADDR  = 0,
   parameter int             STAT_ADDR  = 1,
   parameter int             ADV_ADDR   = 4,
   parameter int             IMASK_ADDR = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tick,
   output logic              busy,
   output logic              done,
   output logic              failed,
   output logic              rst_timeout,
   output logic              req_valid,
   output logic              req_write,
   output logic [PHY_AW-1:0] req_phy,
   output logic [REG_AW-1:0] req_reg,
   output logic [DATA_W-1:0] req_wdata,
   input  logic              mgmt_done,
   input  logic [DATA_W-1:0] mgmt_rdata
);

   // elaboration-time parameter checks
   if (DATA_W != MGMT_DW) begin : g_bad_dw
      $error("phy_bringup_seq: DATA_W must be %0d", MGMT_DW);
   end
   if (RST_POLLS < 1 || ANEG_POLLS < 1) begin : g_bad_polls
      $error("phy_bringup_seq: poll limits must be at least 1");
   end
   if (IMASK_ADDR >= (1 << REG_AW) || ADV_ADDR >= (1 << REG_AW)) begin : g_bad_addr
      $error("phy_bringup_seq: register address does not fit REG_AW");
   end
   if (PHY_AW < 5) begin : g_bad_phyaw
      $error("phy_bringup_seq: PHY_AW must be at least 5");
   end

   seq_state_e        state_q, state_d;
   logic [DATA_W-1:0] adv_q;
   logic [DATA_W-1:0] adv_map;
   logic              fault_q;
   logic              done_q, failed_q, rto_q;

   logic              accept;
   logic              rst_bump, an_bump;
   logic              rst_last, an_last;
   logic              fin, fin_fail, fin_rto;
   logic              cap_take, fault_take;

   assign accept = (state_q == S_IDLE) && start;

   pbs_cap_map #(.DATA_W(DATA_W)) u_cap_map (
      .status_word (mgmt_rdata),
      .adv_word    (adv_map)
   );

   pbs_retry_cnt #(.LIMIT(RST_POLLS)) u_rst_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .bump  (rst_bump),
      .last  (rst_last)
   );

   pbs_retry_cnt #(.LIMIT(ANEG_POLLS)) u_an_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .bump  (an_bump),
      .last  (an_last)
   );

   pbs_req_encode #(
      .DATA_W     (DATA_W),
      .REG_AW     (REG_AW),
      .CTRL_ADDR  (CTRL_ADDR),
      .STAT_ADDR  (STAT_ADDR),
      .ADV_ADDR   (ADV_ADDR),
      .IMASK_ADDR (IMASK_ADDR)
   ) u_req_enc (
      .state    (state_q),
      .adv_word (adv_q),
      .valid    (req_valid),
      .write    (req_write),
      .regnum   (req_reg),
      .wdata    (req_wdata)
   );

   // next-state and event decode
   always_comb begin
      state_d    = state_q;
      rst_bump   = 1'b0;
      an_bump    = 1'b0;
      fin        = 1'b0;
      fin_fail   = 1'b0;
      fin_rto    = 1'b0;
      cap_take   = 1'b0;
      fault_take = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            if (start) state_d = S_WR_RST;
         end
         S_WR_RST: begin
            if (mgmt_done) state_d = S_RD_RST;
         end
         S_RD_RST: begin
            if (mgmt_done) begin
               if (!mgmt_rdata[CTL_RESET]) begin
                  state_d = S_WR_MASK;
               end else if (rst_last) begin
                  state_d  = S_IDLE;
                  fin      = 1'b1;
                  fin_fail = 1'b1;
                  fin_rto  = 1'b1;
               end else begin
                  rst_bump = 1'b1;
                  state_d  = S_WT_RST;
               end
            end
         end
         S_WT_RST: begin
            if (tick) state_d = S_RD_RST;
         end
         S_WR_MASK: begin
            if (mgmt_done) state_d = S_RD_CAP;
         end
         S_RD_CAP: begin
            if (mgmt_done) begin
               cap_take = 1'b1;
               state_d  = S_WR_ADV;
            end
         end
         S_WR_ADV: begin
            if (mgmt_done) state_d = S_WR_ANEG;
         end
         S_WR_ANEG: begin
            if (mgmt_done) state_d = S_RD_ANEG;
         end
         S_RD_ANEG: begin
            if (mgmt_done) begin
               if (mgmt_rdata[STS_AN_DONE]) begin
                  state_d  = S_IDLE;
                  fin      = 1'b1;
                  fin_fail = mgmt_rdata[STS_RFAULT];
               end else if (an_last) begin
                  state_d  = S_IDLE;
                  fin      = 1'b1;
                  fin_fail = 1'b1;
               end else begin
                  an_bump    = 1'b1;
                  fault_take = 1'b1;
                  state_d    = S_WT_ANEG;
               end
            end
         end
         S_WT_ANEG: begin
            if (tick) state_d = fault_q ? S_WR_RETRY : S_RD_ANEG;
         end
         S_WR_RETRY: begin
            if (mgmt_done) state_d = S_RD_ANEG;
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         adv_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (cap_take)   adv_q   <= adv_map;
         if (fault_take) fault_q <= mgmt_rdata[STS_RFAULT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q   <= 1'b0;
         failed_q <= 1'b0;
         rto_q    <= 1'b0;
      end else if (accept) begin
         done_q   <= 1'b0;
         failed_q <= 1'b0;
         rto_q    <= 1'b0;
      end else if (fin) begin
         done_q   <= 1'b1;
         failed_q <= fin_fail;
         rto_q    <= fin_rto;
      end
   end

   assign busy        = (state_q != S_IDLE);
   assign done        = done_q;
   assign failed      = failed_q;
   assign rst_timeout = rto_q;
   assign req_phy     = PHY_AW'(PHY_ADDR);

endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
   parameter int DATA_W = 16,
   parameter int REG_AW = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              failed,
   input logic              rst_timeout,
   input logic              req_valid,
   input logic              req_write,
   input logic [REG_AW-1:0] req_reg,
   input logic [DATA_W-1:0] req_wdata,
   input logic              mgmt_done
);

   // R10: a request stays up, unchanged, until the master completes it
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mgmt_done) |=>
         (req_valid && $stable(req_write) && $stable(req_reg) && $stable(req_wdata)))
      else $error("p_req_hold_r10");

   // R10: requests only while a sequence runs
   p_valid_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> busy)
      else $error("p_valid_busy_r10");

   // R11: flags are clear when a sequence begins
   p_flags_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!done && !failed && !rst_timeout))
      else $error("p_flags_clear_r11");

   // R9: every sequence end raises done
   p_end_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done)
      else $error("p_end_done_r9");

   // R3: a reset timeout is always reported as a finished failure
   p_timeout_failed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rst_timeout |-> (failed && done && !busy))
      else $error("p_timeout_failed_r3");

endmodule

bind phy_bringup_seq pbs_checker #(
   .DATA_W (DATA_W),
   .REG_AW (REG_AW)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .failed      (failed),
   .rst_timeout (rst_timeout),
   .req_valid   (req_valid),
   .req_write   (req_write),
   .req_reg     (req_reg),
   .req_wdata   (req_wdata),
   .mgmt_done   (mgmt_done)
);

// File: tb/phy_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module phy_bringup_seq_tb_top;

   localparam logic [4:0] T_PHY = 5'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        tick = 1'b0;
   logic        busy, done, failed, rst_timeout;
   logic        req_valid, req_write;
   logic [4:0]  req_phy, req_reg;
   logic [15:0] req_wdata;
   logic        mgmt_done = 1'b0;
   logic [15:0] mgmt_rdata = '0;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   phy_bringup_seq #(.PHY_ADDR(T_PHY)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .tick        (tick),
      .busy        (busy),
      .done        (done),
      .failed      (failed),
      .rst_timeout (rst_timeout),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_phy     (req_phy),
      .req_reg     (req_reg),
      .req_wdata   (req_wdata),
      .mgmt_done   (mgmt_done),
      .mgmt_rdata  (mgmt_rdata)
   );

   // scripted PHY behind the management master
   int          rst_clear_at, aneg_ok_at;
   logic [31:0] fault_mask;
   logic [15:0] caps;
   int          ctl_reads, sts_reads, nwr, bad_phy, gap_err, lat, tcnt, k;
   logic        tick_seen;
   logic [4:0]  wr_reg [64];
   logic [15:0] wr_dat [64];

   always @(posedge clk) begin
      tcnt = (tcnt + 1) % 8;
      tick <= (tcnt == 0);
      mgmt_done <= 1'b0;
      if (req_valid && !mgmt_done) begin
         if (lat == 2) begin
            lat = 0;
            mgmt_done <= 1'b1;
            if (req_phy !== T_PHY) bad_phy++;
            if (req_write) begin
               if (nwr < 64) begin
                  wr_reg[nwr] = req_reg;
                  wr_dat[nwr] = req_wdata;
               end
               nwr++;
            end else if (req_reg == 5'd0) begin
               ctl_reads++;
               if (ctl_reads > 1 && !tick_seen) gap_err++;
               tick_seen = 1'b0;
               mgmt_rdata <= (rst_clear_at > 0 && ctl_reads >= rst_clear_at) ? 16'h0000 : 16'h8000;
            end else begin
               sts_reads++;
               if (sts_reads == 1) begin
                  mgmt_rdata <= caps;
               end else begin
                  k = sts_reads - 1;
                  if (k > 1 && !tick_seen) gap_err++;
                  tick_seen = 1'b0;
                  mgmt_rdata <= caps
                     | ((aneg_ok_at > 0 && k >= aneg_ok_at) ? 16'h0020 : 16'h0000)
                     | ((k < 32 && fault_mask[k]) ? 16'h0010 : 16'h0000);
               end
            end
         end else begin
            lat = lat + 1;
         end
      end
      if (tick) tick_seen = 1'b1;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic setup(input int rca, input int aoa, input logic [31:0] fm,
                        input logic [15:0] c);
      @(negedge clk);
      rst_clear_at = rca;
      aneg_ok_at   = aoa;
      fault_mask   = fm;
      caps         = c;
      ctl_reads    = 0;
      sts_reads    = 0;
      nwr          = 0;
      bad_phy      = 0;
      gap_err      = 0;
      tick_seen    = 1'b0;
   endtask

   task automatic run_seq(input int extra_start_at);
      int n;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      n = 1;
      while (busy) begin
         @(negedge clk);
         n++;
         start = (n == extra_start_at);
      end
      start = 1'b0;
   endtask

   task automatic chk_wr(input string req, input int idx,
                         input logic [4:0] r, input logic [15:0] d);
      chk(req, $sformatf("write %0d register", idx), 32'(wr_reg[idx]), 32'(r));
      chk(req, $sformatf("write %0d data", idx), 32'(wr_dat[idx]), 32'(d));
   endtask

   task automatic t_reset_state;
      chk("R13", "busy after reset", 32'(busy), 0);
      chk("R13", "done after reset", 32'(done), 0);
      chk("R13", "failed after reset", 32'(failed), 0);
      chk("R13", "rst_timeout after reset", 32'(rst_timeout), 0);
      chk("R13", "req_valid after reset", 32'(req_valid), 0);
   endtask

   task automatic t_nominal;
      setup(2, 3, 32'h0, 16'hF800);
      run_seq(12);   // second start while busy must be ignored (R11)
      chk("R1", "write count", 32'(nwr), 4);
      chk_wr("R1", 0, 5'd0, 16'h8000);
      chk_wr("R4", 1, 5'd18, 16'hFFFF);
      chk_wr("R5", 2, 5'd4, 16'h03E1);
      chk_wr("R6", 3, 5'd0, 16'h1200);
      chk("R2", "control reads", 32'(ctl_reads), 2);
      chk("R7", "status reads", 32'(sts_reads), 4);
      chk("R7", "polls without tick", 32'(gap_err), 0);
      chk("R12", "wrong phy address", 32'(bad_phy), 0);
      chk("R9", "done", 32'(done), 1);
      chk("R9", "failed", 32'(failed), 0);
      chk("R9", "rst_timeout", 32'(rst_timeout), 0);
      repeat (30) @(negedge clk);
      chk("R11", "busy after ignored start", 32'(busy), 0);
      chk("R11", "writes after ignored start", 32'(nwr), 4);
      chk("R11", "done held", 32'(done), 1);
   endtask

   task automatic t_caps;
      setup(1, 1, 32'h0, 16'h5000);
      run_seq(0);
      chk_wr("R5", 2, 5'd4, 16'h0141);
      chk("R9", "failed", 32'(failed), 0);
      setup(1, 1, 32'h0, 16'hA800);
      run_seq(0);
      chk_wr("R5", 2, 5'd4, 16'h02A1);
      chk("R2", "single control read", 32'(ctl_reads), 1);
   endtask

   task automatic t_rst_timeout;
      setup(0, 1, 32'h0, 16'h0000);
      run_seq(0);
      chk("R3", "control reads", 32'(ctl_reads), 6);
      chk("R3", "write count", 32'(nwr), 1);
      chk("R3", "status reads", 32'(sts_reads), 0);
      chk("R3", "done", 32'(done), 1);
      chk("R3", "failed", 32'(failed), 1);
      chk("R3", "rst_timeout", 32'(rst_timeout), 1);
      chk("R2", "polls without tick", 32'(gap_err), 0);
   endtask

   task automatic t_rst_last_poll;
      setup(6, 1, 32'h0, 16'h0000);
      run_seq(0);
      chk("R2", "control reads", 32'(ctl_reads), 6);
      chk("R2", "write count", 32'(nwr), 4);
      chk("R11", "rst_timeout cleared", 32'(rst_timeout), 0);
      chk("R11", "failed cleared", 32'(failed), 0);
      chk_wr("R5", 2, 5'd4, 16'h0001);
   endtask

   task automatic t_an_timeout;
      setup(1, 0, 32'h0, 16'h0000);
      run_seq(0);
      chk("R7", "status reads", 32'(sts_reads), 21);
      chk("R7", "polls without tick", 32'(gap_err), 0);
      chk("R9", "done", 32'(done), 1);
      chk("R9", "failed", 32'(failed), 1);
      chk("R9", "rst_timeout", 32'(rst_timeout), 0);
      chk("R9", "write count", 32'(nwr), 4);
   endtask

   task automatic t_fault_restart;
      setup(1, 3, 32'h0000_0002, 16'h0000);
      run_seq(0);
      chk("R8", "write count", 32'(nwr), 5);
      chk_wr("R8", 4, 5'd0, 16'h3300);
      chk("R8", "status reads", 32'(sts_reads), 4);
      chk("R8", "failed", 32'(failed), 0);
   endtask

   task automatic t_fault_final;
      setup(1, 2, 32'h0000_0004, 16'h0000);
      run_seq(0);
      chk("R9", "write count", 32'(nwr), 4);
      chk("R9", "status reads", 32'(sts_reads), 3);
      chk("R9", "done", 32'(done), 1);
      chk("R9", "failed", 32'(failed), 1);
   endtask

   initial begin
      tcnt = 0;
      lat  = 0;
      setup(1, 1, 32'h0, 16'h0);
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset_state();
      t_nominal();
      t_caps();
      t_rst_timeout();
      t_rst_last_poll();
      t_an_timeout();
      t_fault_restart();
      t_fault_final();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule